// File: doc/BRIEF.md
# Adaptive Sequence-Selective Harmonic Filter Bank

This block separates a three-phase signal, given as a complex alpha/beta sample, into rotating components. It holds a bank of first-order complex bandpass branches. Each branch is centred on a signed multiple of the fundamental angular frequency. A positive order passes only counter-clockwise rotation, which is positive sequence. A negative order passes only clockwise rotation, which is negative sequence.

The fundamental frequency is not fixed. With every sample, the block takes a per-sample phase step from an external phase tracker. All branches share one error term: the input minus the sum of every branch output from the previous sample. Each branch therefore sees the input with the other branches' estimates removed, and the branches settle on disjoint parts of the spectrum.

The branches are computed one per clock over a single shared datapath. The new state of a branch is written as soon as it is computed, but the outputs do not move during a pass. All outputs are updated together at the end of the pass and marked by a one-cycle valid pulse. The output of the +1 branch is also presented on separate ports as the filtered fundamental for the tracker.

Top module: `cplx_harm_bank`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, all branch states and outputs are cleared to zero, the block becomes idle and `valid_o` is low.
- R2: A strobe accepted while the block is idle produces exactly one `valid_o` pulse, one cycle long. The pulse goes high NBR clock edges after the edge that sampled the strobe.
- R3: With one error per sample, e = x − (sum of all NBR branch outputs held before this sample), each branch k updates as z_k ← z_k + ((GAIN·e) >>> FB) + rotation. The same error is applied to the real and imaginary parts.
- R4: The rotation of branch k uses p = h_k·w. The real part gains −((p·Im z_k) >>> FB) and the imaginary part gains +((p·Re z_k) >>> FB). With the default parameters the branch orders h are, from index 0 to 3: +1, −1, −5, +7.
- R5: All samples, states and the phase step are two's-complement values DW bits wide with FB fractional bits. Each product is shifted right arithmetically by FB, which rounds toward minus infinity.
- R6: Any updated state above 2^(DW−1)−1 or below −2^(DW−1) is clamped to that limit.
- R7: A strobe that arrives while a pass is in progress is ignored. Neither that pass nor any later result depends on it.
- R8: The outputs change only together with `valid_o`. They hold their values between pulses.
- R9: `fund_re_o` and `fund_im_o` always equal the outputs of branch FUND_IDX, which is index 0 by default.
- R10: The input sample and `w_i` are captured at the strobe edge. Changing them during a pass has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | New sample present |
| x_re_i | input | DW | Alpha part of the input sample |
| x_im_i | input | DW | Beta part of the input sample |
| w_i | input | DW | Fundamental phase step per sample (ω1·Ts) |
| valid_o | output | 1 | One-cycle pulse when all outputs update |
| z_re_o | output | NBR·DW | Real parts of the branch outputs, branch k at bits k·DW |
| z_im_o | output | NBR·DW | Imaginary parts of the branch outputs |
| fund_re_o | output | DW | Real part of the fundamental branch |
| fund_im_o | output | DW | Imaginary part of the fundamental branch |

## Verification
Two events can fall in the same cycle. A new strobe can arrive while a pass is still sequencing the branches. The input operands and the phase step can also change in a cycle where the datapath is still using the values captured earlier.

The bench provokes both cases on purpose. In a share of its samples it pulses a second strobe two cycles into the pass and drives fresh random values for the sample and the phase step while the pass runs. The result is judged against a bench model that sees only the accepted sample. The bench also checks that the pulse latency is unchanged, so a design that accepts the stray strobe, or that reads the live inputs, produces a mismatch on some branch.

// File: rtl/cplx_harm_bank.sv
module cplx_harm_bank #(
  parameter int DW = 24,
  parameter int FB = 20,
  parameter int NBR = 4,
  parameter logic [NBR*8-1:0] HARM = {8'h07, 8'hFB, 8'hFF, 8'h01},
  parameter int GAIN = 1164,
  parameter int FUND_IDX = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  strobe_i,
  input  logic signed [DW-1:0]  x_re_i,
  input  logic signed [DW-1:0]  x_im_i,
  input  logic signed [DW-1:0]  w_i,
  output logic                  valid_o,
  output logic [NBR*DW-1:0]     z_re_o,
  output logic [NBR*DW-1:0]     z_im_o,
  output logic signed [DW-1:0]  fund_re_o,
  output logic signed [DW-1:0]  fund_im_o
);

  localparam int PW = 2*DW + 8;
  localparam int IW = (NBR > 1) ? $clog2(NBR) : 1;
  localparam logic [IW-1:0] LAST = IW'(NBR-1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW-1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW-1));

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] st_re [NBR];
  logic signed [DW-1:0] st_im [NBR];
  logic signed [DW-1:0] sh_re [NBR];
  logic signed [DW-1:0] sh_im [NBR];
  logic signed [7:0]    hv    [NBR];
  logic                 busy;
  logic [IW-1:0]        idx;
  logic signed [DW-1:0] w_q;
  logic signed [PW-1:0] ae_re_q, ae_im_q;
  logic signed [PW-1:0] sum_re, sum_im, ae_re, ae_im;
  logic signed [PW-1:0] hw, rot_re, rot_im;
  logic signed [DW-1:0] cur_re, cur_im, new_re, new_im;
  logic                 accept;

  for (genvar k = 0; k < NBR; k++) begin : g_br
    assign hv[k] = HARM[8*k +: 8];
    assign z_re_o[k*DW +: DW] = st_re[k];
    assign z_im_o[k*DW +: DW] = st_im[k];
  end

  assign fund_re_o = st_re[FUND_IDX];
  assign fund_im_o = st_im[FUND_IDX];
  assign accept = strobe_i && !busy;

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int k = 0; k < NBR; k++) begin
      sum_re = sum_re + PW'(st_re[k]);
      sum_im = sum_im + PW'(st_im[k]);
    end
    ae_re = (PW'(GAIN) * (PW'(x_re_i) - sum_re)) >>> FB;
    ae_im = (PW'(GAIN) * (PW'(x_im_i) - sum_im)) >>> FB;
  end

  assign cur_re = st_re[idx];
  assign cur_im = st_im[idx];
  assign hw     = PW'(hv[idx]) * PW'(w_q);
  assign rot_re = (hw * PW'(cur_im)) >>> FB;
  assign rot_im = (hw * PW'(cur_re)) >>> FB;
  assign new_re = sat(PW'(cur_re) + ae_re_q - rot_re);
  assign new_im = sat(PW'(cur_im) + ae_im_q + rot_im);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy    <= 1'b0;
      idx     <= '0;
      valid_o <= 1'b0;
      w_q     <= '0;
      ae_re_q <= '0;
      ae_im_q <= '0;
      for (int k = 0; k < NBR; k++) begin
        st_re[k] <= '0;
        st_im[k] <= '0;
        sh_re[k] <= '0;
        sh_im[k] <= '0;
      end
    end else begin
      valid_o <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        idx     <= '0;
        w_q     <= w_i;
        ae_re_q <= ae_re;
        ae_im_q <= ae_im;
      end else if (busy) begin
        sh_re[idx] <= new_re;
        sh_im[idx] <= new_im;
        if (idx == LAST) begin
          busy    <= 1'b0;
          valid_o <= 1'b1;
          for (int k = 0; k < NBR; k++) begin
            st_re[k] <= (k == int'(idx)) ? new_re : sh_re[k];
            st_im[k] <= (k == int'(idx)) ? new_im : sh_im[k];
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  logic [IW+1:0] lat_cnt;
  always_ff @(posedge clk_i) begin
    if (rst_i) lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 1'b1;
  end

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (lat_cnt == (IW+2)'(NBR)));

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !($stable(z_re_o) && $stable(z_im_o)) |-> valid_o);

  assert_ignore_busy_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && strobe_i && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

endmodule

// File: tb/cplx_harm_bank_tb.sv
`timescale 1ns/1ps
module cplx_harm_bank_tb_top;
  localparam int DW = 24;
  localparam int FB = 20;
  localparam int NBR = 4;
  localparam int GAIN = 1164;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));
  localparam longint ONE = 64'sd1 <<< FB;

  logic clk = 0, rst = 1, strobe = 0;
  logic signed [DW-1:0] x_re = '0, x_im = '0, w = '0;
  logic valid;
  logic [NBR*DW-1:0] z_re, z_im;
  logic signed [DW-1:0] f_re, f_im;

  int n_chk = 0, n_fail = 0;
  longint m_re [NBR];
  longint m_im [NBR];
  longint harm [NBR] = '{1, -1, -5, 7};

  always #10 clk = ~clk;

  cplx_harm_bank #(.DW(DW), .FB(FB), .NBR(NBR), .GAIN(GAIN)) dut_i (
    .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .x_re_i(x_re), .x_im_i(x_im),
    .w_i(w), .valid_o(valid), .z_re_o(z_re), .z_im_o(z_im),
    .fund_re_o(f_re), .fund_im_o(f_im));

  function automatic longint clamp(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint dout(logic [NBR*DW-1:0] bus, int k);
    logic signed [DW-1:0] s;
    s = bus[k*DW +: DW];
    return longint'(s);
  endfunction

  task automatic model_step(longint xr, longint xi, longint ws);
    longint sr = 0, si = 0, ar, ai, p, nr, ni;
    for (int k = 0; k < NBR; k++) begin sr += m_re[k]; si += m_im[k]; end
    ar = (GAIN * (xr - sr)) >>> FB;
    ai = (GAIN * (xi - si)) >>> FB;
    for (int k = 0; k < NBR; k++) begin
      p  = harm[k] * ws;
      nr = clamp(m_re[k] + ar - ((p * m_im[k]) >>> FB));
      ni = clamp(m_im[k] + ai + ((p * m_re[k]) >>> FB));
      m_re[k] = nr;
      m_im[k] = ni;
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit ok = 1;
    for (int k = 0; k < NBR; k++) begin
      if (dout(z_re, k) != m_re[k] || dout(z_im, k) != m_im[k]) begin
        ok = 0;
        $display("FAIL %s branch %0d actual=(%0d,%0d) expected=(%0d,%0d)", req, k,
                 dout(z_re, k), dout(z_im, k), m_re[k], m_im[k]);
      end
    end
    n_chk++;
    if (!ok) n_fail++;
    check(longint'(f_re) == m_re[0] && longint'(f_im) == m_im[0], "R9", "fund",
          longint'(f_re), m_re[0]);
  endtask

  task automatic send(longint xr, longint xi, longint ws, bit stray, string req);
    int lat = 0;
    @(negedge clk);
    strobe = 1; x_re = xr[DW-1:0]; x_im = xi[DW-1:0]; w = ws[DW-1:0];
    @(negedge clk);
    strobe = 0;
    x_re = DW'($urandom); x_im = DW'($urandom); w = DW'($urandom);
    do begin
      @(negedge clk);
      lat++;
      if (stray && lat == 2) begin strobe = 1; x_re = DW'($urandom); end
      if (lat == 3) strobe = 0;
    end while (!valid && lat < 50);
    model_step(xr, xi, ws);
    check(lat == NBR, "R2", "latency", lat, NBR);
    check_all(req);
    @(negedge clk);
    check(!valid, "R2", "single pulse", valid, 0);
    check_all("R8");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit sat_seen;
    longint b0_im, b1_im;
    void'($urandom(32'd2024));
    for (int k = 0; k < NBR; k++) begin m_re[k] = 0; m_im[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!valid, "R1", "valid after reset", valid, 0);
    check_all("R1");

    send(0, 0, 1647, 0, "R3");
    send(ONE, 0, 1647, 0, "R3");
    send(ONE, 0, 1647, 0, "R4");
    b0_im = dout(z_im, 0); b1_im = dout(z_im, 1);
    check(b0_im > b1_im, "R4", "rotation sign h=+1 vs h=-1", b0_im, b1_im);
    send(-ONE/2, ONE/3, 3000, 1, "R7");
    send(ONE/4, -ONE, 2500, 1, "R10");
    send(-ONE, -ONE, 1647, 0, "R5");

    for (int i = 0; i < 6; i++) send(MAXV, MINV, MAXV, 0, "R6");
    sat_seen = 0;
    for (int k = 0; k < NBR; k++)
      if (dout(z_re, k) == MAXV || dout(z_re, k) == MINV ||
          dout(z_im, k) == MAXV || dout(z_im, k) == MINV) sat_seen = 1;
    check(sat_seen, "R6", "limit reached", sat_seen, 1);

    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int k = 0; k < NBR; k++) begin m_re[k] = 0; m_im[k] = 0; end
    @(negedge clk);
    check_all("R1");

    for (int i = 0; i < 250; i++) begin
      longint xr, xi, ws;
      xr = longint'($urandom_range(0, 2*ONE)) - ONE;
      xi = longint'($urandom_range(0, 2*ONE)) - ONE;
      ws = 1647 + longint'($urandom_range(0, 600)) - 300;
      send(xr, xi, ws, ($urandom_range(0, 3) == 0), "R3");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule